// File: doc/BRIEF.md
# Lane Sync-Code Word Aligner

This block sits behind one receive lane of a serial transceiver that has already recovered 8b10b symbols. Each cycle it may take one 32-bit word of four decoded bytes, with one flag per byte that marks a control character. The transceiver's word boundary is arbitrary with respect to the sender's symbol groups. The aligner watches the byte stream for the four-symbol synchronisation code, which may start in any of the four byte positions of a word. It notes that position and from then on re-packs the stream so that every output word starts on the sync code's boundary.

Matching runs over a two-word window made of the previous accepted word and the current one, so a code that straddles two words is found at any rotation. After lock, each accepted word yields one aligned word on the next cycle. The first of these words is the sync code itself. The lane's ready qualifier drops the lock and restarts the search. The valid qualifier gates every step: on a cycle without valid nothing moves.

Top module: `lane_sync_aligner`

## Requirements
- R1: After reset, `al_valid` and `al_locked` are low and `al_data` and `al_kflag` are zero.
- R2: Byte i of `rx_data` is bits [8i+7:8i], its control flag is `rx_kflag[i]`, and byte 0 is earliest in time. The sync code is 0xBC with flag 1, then three bytes of 0xAA with flag 0.
- R3: A word is accepted when `rx_ready` and `rx_valid` are both high. If an accepted word completes a sync code that began in the previous accepted word, `al_locked` is high from the next cycle. This holds whichever of byte offsets 0 to 3 the code began at.
- R4: Starting with the word that completes the sync code, each accepted word while locked gives `al_valid` high one cycle later. The same cycle carries, on `al_data`/`al_kflag`, the next four stream bytes counted from the sync code's first byte. The first such word is the sync code itself.
- R5: While unlocked, `al_valid` stays low. Idle words of 0x00 data bytes do not cause lock. Near misses do not cause lock either: 0xBC without its flag, 0xAA with its flag set, or a wrong fourth byte.
- R6: On a cycle with `rx_ready` high and `rx_valid` low, the word is ignored even if it holds a sync code. `al_valid` is low on the next cycle, `al_locked` is unchanged, and the alignment of later words is not disturbed.
- R7: A cycle with `rx_ready` low clears `al_locked` and `al_valid` on the next cycle. It also discards the held previous word, so a sync code split around the drop is not matched.
- R8: While locked, a sync code at a different byte offset does not change the alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_ready | input | 1 | Lane ready; low clears lock and history |
| rx_valid | input | 1 | Word qualifier from the transceiver |
| rx_data | input | 32 | Four decoded bytes, byte 0 earliest |
| rx_kflag | input | 4 | Control-character flag per byte |
| al_data | output | 32 | Aligned word, byte 0 earliest |
| al_kflag | output | 4 | Control flags of the aligned word |
| al_valid | output | 1 | Aligned word present |
| al_locked | output | 1 | Sync code found and offset held |

## Verification
Two functions can fall in the same cycle: detecting the sync code and emitting the first aligned word. The bench places the code at each of the four offsets, behind several kinds of decoy filler, and checks that the first valid output word is exactly the sync bytes in the cycle that lock rises. A second pairing is a valid-low gap that carries a full sync code while a straddling code is still half received. This is provoked by inserting such gaps between words, and it is judged by lock timing and by the byte offset of every later output word.

// File: rtl/lsa_pkg.sv
// Shared constants for the lane sync-code aligner.
// Assumes symbols arrive already 8b10b-decoded, one byte plus a control flag each.
package lsa_pkg;
    localparam int SYM_W   = 8;
    localparam int PAT_LEN = 4;
    localparam logic [SYM_W-1:0] SYNC_HEAD = 8'hBC;   // control comma symbol
    localparam logic [SYM_W-1:0] SYNC_BODY = 8'hAA;   // data symbol repeated three times

    // Expected byte value at position idx of the sync code.
    function automatic logic [SYM_W-1:0] pat_sym(input int idx);
        return (idx == 0) ? SYNC_HEAD : SYNC_BODY;
    endfunction

    // Expected control flag at position idx of the sync code.
    function automatic logic pat_is_k(input int idx);
        return (idx == 0);
    endfunction
endpackage

// File: rtl/lsa_history.sv
// Holds the previous accepted word and forms the two-word search window.
// The previous word sits in the low half (earlier bytes). Assumes take = ready & valid.
module lsa_history #(
    parameter int LANE_BYTES = 4,
    localparam int WORD_W = LANE_BYTES * lsa_pkg::SYM_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ready,
    input  logic                      take,
    input  logic [WORD_W-1:0]         cur_data,
    input  logic [LANE_BYTES-1:0]     cur_k,
    output logic [2*WORD_W-1:0]       win_data,
    output logic [2*LANE_BYTES-1:0]   win_k,
    output logic                      prev_ok
);
    logic [WORD_W-1:0]     prev_data;
    logic [LANE_BYTES-1:0] prev_k;

    // Capture each accepted word; forget history when the lane is not ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_data <= '0;
            prev_k    <= '0;
            prev_ok   <= 1'b0;
        end else if (!ready) begin
            prev_ok   <= 1'b0;
        end else if (take) begin
            prev_data <= cur_data;
            prev_k    <= cur_k;
            prev_ok   <= 1'b1;
        end
    end

    assign win_data = {cur_data, prev_data};
    assign win_k    = {cur_k, prev_k};
endmodule

// File: rtl/lsa_detect.sv
// Compares the sync code against every start offset inside the previous word.
// Reports any hit and the lowest matching offset. Assumes LANE_BYTES >= PAT_LEN - 1.
module lsa_detect #(
    parameter int LANE_BYTES = 4,
    localparam int WORD_W = LANE_BYTES * lsa_pkg::SYM_W,
    localparam int OFF_W  = (LANE_BYTES > 1) ? $clog2(LANE_BYTES) : 1
) (
    input  logic [2*WORD_W-1:0]     win_data,
    input  logic [2*LANE_BYTES-1:0] win_k,
    input  logic                    prev_ok,
    output logic                    hit,
    output logic [OFF_W-1:0]        hit_off
);
    localparam int SW = lsa_pkg::SYM_W;

    logic [LANE_BYTES-1:0] hit_vec;

    for (genvar o = 0; o < LANE_BYTES; o++) begin : g_off
        logic m;
        // Match all symbols of the sync code starting at byte o of the window.
        always_comb begin
            m = prev_ok;
            for (int j = 0; j < lsa_pkg::PAT_LEN; j++) begin
                if (win_data[(o+j)*SW +: SW] != lsa_pkg::pat_sym(j) ||
                    win_k[o+j] != lsa_pkg::pat_is_k(j))
                    m = 1'b0;
            end
        end
        assign hit_vec[o] = m;
    end

    // Priority encode, lowest offset wins.
    always_comb begin
        hit_off = '0;
        for (int o = LANE_BYTES - 1; o >= 0; o--) begin
            if (hit_vec[o]) hit_off = OFF_W'(o);
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/lsa_lock.sv
// Lock state: records the offset of the first sync code found and holds it
// until the lane drops ready. Produces the offset used by the rotator.
module lsa_lock #(
    parameter int LANE_BYTES = 4,
    localparam int OFF_W = (LANE_BYTES > 1) ? $clog2(LANE_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ready,
    input  logic             take,
    input  logic             hit,
    input  logic [OFF_W-1:0] hit_off,
    output logic             locked,
    output logic [OFF_W-1:0] sel_off,
    output logic             emit
);
    logic [OFF_W-1:0] off_q;

    // Enter lock on the first hit of an accepted word; leave only when ready drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            off_q  <= '0;
        end else if (!ready) begin
            locked <= 1'b0;
        end else if (take && !locked && hit) begin
            locked <= 1'b1;
            off_q  <= hit_off;
        end
    end

    // Offset in force for this word and whether it produces output.
    assign sel_off = locked ? off_q : hit_off;
    assign emit    = take && (locked || hit);
endmodule

// File: rtl/lsa_rotate.sv
// Selects LANE_BYTES consecutive bytes from the window at the chosen offset
// and registers them as the aligned output word (one cycle of latency).
module lsa_rotate #(
    parameter int LANE_BYTES = 4,
    localparam int WORD_W = LANE_BYTES * lsa_pkg::SYM_W,
    localparam int OFF_W  = (LANE_BYTES > 1) ? $clog2(LANE_BYTES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ready,
    input  logic                      take,
    input  logic                      emit,
    input  logic [OFF_W-1:0]          sel_off,
    input  logic [2*WORD_W-1:0]       win_data,
    input  logic [2*LANE_BYTES-1:0]   win_k,
    output logic [WORD_W-1:0]         out_data,
    output logic [LANE_BYTES-1:0]     out_k,
    output logic                      out_valid
);
    localparam int SW = lsa_pkg::SYM_W;

    logic [WORD_W-1:0]     rot_data;
    logic [LANE_BYTES-1:0] rot_k;

    for (genvar b = 0; b < LANE_BYTES; b++) begin : g_byte
        // Pick window byte sel_off + b for output byte b.
        always_comb begin
            rot_data[b*SW +: SW] = win_data[(int'(sel_off) + b)*SW +: SW];
            rot_k[b]             = win_k[int'(sel_off) + b];
        end
    end

    // Output register: new word on emit, data held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_k     <= '0;
            out_valid <= 1'b0;
        end else if (!ready || !take) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_data <= rot_data;
                out_k    <= rot_k;
            end
        end
    end
endmodule

// File: rtl/lane_sync_aligner.sv
// Top of the lane sync-code aligner. Finds the sync code at any byte rotation
// of the decoded word stream, locks that rotation and outputs aligned words.
// Assumes one lane, one word per cycle at most, byte 0 earliest in time.
module lane_sync_aligner #(
    parameter int LANE_BYTES = 4,
    localparam int WORD_W = LANE_BYTES * lsa_pkg::SYM_W,
    localparam int OFF_W  = (LANE_BYTES > 1) ? $clog2(LANE_BYTES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_ready,
    input  logic                  rx_valid,
    input  logic [WORD_W-1:0]     rx_data,
    input  logic [LANE_BYTES-1:0] rx_kflag,
    output logic [WORD_W-1:0]     al_data,
    output logic [LANE_BYTES-1:0] al_kflag,
    output logic                  al_valid,
    output logic                  al_locked
);
    logic                    take;
    logic [2*WORD_W-1:0]     win_data;
    logic [2*LANE_BYTES-1:0] win_k;
    logic                    prev_ok;
    logic                    hit;
    logic [OFF_W-1:0]        hit_off;
    logic [OFF_W-1:0]        sel_off;
    logic                    emit;

    assign take = rx_ready && rx_valid;

    lsa_history #(.LANE_BYTES(LANE_BYTES)) u_history (
        .clk(clk), .rst_n(rst_n), .ready(rx_ready), .take(take),
        .cur_data(rx_data), .cur_k(rx_kflag),
        .win_data(win_data), .win_k(win_k), .prev_ok(prev_ok)
    );

    lsa_detect #(.LANE_BYTES(LANE_BYTES)) u_detect (
        .win_data(win_data), .win_k(win_k), .prev_ok(prev_ok),
        .hit(hit), .hit_off(hit_off)
    );

    lsa_lock #(.LANE_BYTES(LANE_BYTES)) u_lock (
        .clk(clk), .rst_n(rst_n), .ready(rx_ready), .take(take),
        .hit(hit), .hit_off(hit_off),
        .locked(al_locked), .sel_off(sel_off), .emit(emit)
    );

    lsa_rotate #(.LANE_BYTES(LANE_BYTES)) u_rotate (
        .clk(clk), .rst_n(rst_n), .ready(rx_ready), .take(take), .emit(emit),
        .sel_off(sel_off), .win_data(win_data), .win_k(win_k),
        .out_data(al_data), .out_k(al_kflag), .out_valid(al_valid)
    );
endmodule

// File: rtl/lsa_checker.sv
// Temporal checks on the aligner's ports, bound into every instance.
module lsa_checker (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      rx_ready,
    input logic                      rx_valid,
    input logic                      al_valid,
    input logic                      al_locked,
    input logic [lsa_pkg::SYM_W-1:0] lead_sym,
    input logic                      lead_k
);
    // R5: no aligned output unless locked
    a_r5_out_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        al_valid |-> al_locked);

    // R6: a gap cycle yields no output word
    a_r6_gap_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rx_valid) |=> !al_valid);

    // R6: a gap cycle leaves lock unchanged
    a_r6_gap_keeps_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rx_valid) |=> (al_locked == $past(al_locked)));

    // R7: ready low clears lock and output
    a_r7_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |=> (!al_locked && !al_valid));

    // R8: lock persists while ready stays high
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (al_locked && rx_ready) |=> al_locked);

    // R4: the cycle lock rises carries the sync code's head symbol
    a_r4_first_is_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(al_locked) |-> (al_valid && lead_k && lead_sym == lsa_pkg::SYNC_HEAD));
endmodule

bind lane_sync_aligner lsa_checker u_lsa_checker (
    .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .rx_valid(rx_valid),
    .al_valid(al_valid), .al_locked(al_locked),
    .lead_sym(al_data[lsa_pkg::SYM_W-1:0]), .lead_k(al_kflag[0])
);

// File: tb/test_lane_sync_aligner.sv
`timescale 1ns/1ps
module test_lane_sync_aligner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic [3:0]  rx_kflag = '0;
    logic [31:0] al_data;
    logic [3:0]  al_kflag;
    logic        al_valid;
    logic        al_locked;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0] sb [0:47];
    logic       sk [0:47];

    always #2 clk = ~clk;

    lane_sync_aligner i_lane_sync_aligner (
        .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_kflag(rx_kflag),
        .al_data(al_data), .al_kflag(al_kflag),
        .al_valid(al_valid), .al_locked(al_locked)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs, then sample 1 ns after the edge.
    task automatic push(input logic [31:0] d, input logic [3:0] k, input logic v, input logic r);
        rx_data = d; rx_kflag = k; rx_valid = v; rx_ready = r;
        @(posedge clk);
        #1;
    endtask

    // Filler byte i of decoy kind; none of these forms a sync code.
    function automatic logic [8:0] filler(input int kind, input int i);
        logic [7:0] pb [0:3];
        pb[0] = 8'hBC; pb[1] = 8'hAA; pb[2] = 8'hAA; pb[3] = 8'hAA;
        case (kind)
            0: return {1'b0, 8'h00};                               // idle
            1: return {1'b0, pb[i%4]};                             // head without flag
            2: return {(i%4 == 0) || (i%4 == 1), pb[i%4]};         // body byte flagged
            default: return {(i%4 == 0), (i%4 == 3) ? 8'h55 : pb[i%4]}; // wrong 4th byte
        endcase
    endfunction

    task automatic run_case(input int off, input int kind, input bit gaps);
        int s;
        int w;
        int p;
        logic [31:0] d;
        logic [3:0]  k;
        logic [31:0] ed;
        logic [3:0]  ek;
        logic        exp_lock;
        s = 12 + off;
        w = s / 4;
        p = s + 17;   // R8 decoy at a different offset
        for (int i = 0; i < 48; i++) begin
            logic [8:0] f;
            if (i < s) begin
                f = filler(kind, i);
                sb[i] = f[7:0]; sk[i] = f[8];
            end else if (i < s + 4) begin
                sb[i] = (i == s) ? 8'hBC : 8'hAA; sk[i] = (i == s);
            end else if (i >= p && i < p + 4) begin
                sb[i] = (i == p) ? 8'hBC : 8'hAA; sk[i] = (i == p);
            end else begin
                sb[i] = 8'((i * 29 + 3) & 8'hFF); sk[i] = (i % 5 == 0);
            end
        end
        // R7: ready low restarts the search
        push(32'h0, 4'h0, 1'b1, 1'b0);
        chk("R7 lock cleared", 64'(al_locked), 64'd0);
        chk("R7 output cleared", 64'(al_valid), 64'd0);
        for (int m = 0; m < 10; m++) begin
            exp_lock = (m >= w + 1);
            if (gaps && (m % 3 == 1)) begin
                // R6: ignored word holding a full sync code
                push(32'hAAAAAABC, 4'b0001, 1'b0, 1'b1);
                chk("R6 gap no output", 64'(al_valid), 64'd0);
                chk("R6 gap lock held", 64'(al_locked), 64'(m - 1 >= w + 1));
            end
            for (int b = 0; b < 4; b++) begin
                d[b*8 +: 8] = sb[4*m + b];
                k[b] = sk[4*m + b];
            end
            push(d, k, 1'b1, 1'b1);
            chk(exp_lock ? "R3 lock at offset" : "R5 no false lock", 64'(al_locked), 64'(exp_lock));
            chk(exp_lock ? "R4 output valid" : "R5 silent unlocked", 64'(al_valid), 64'(exp_lock));
            if (exp_lock) begin
                for (int b = 0; b < 4; b++) begin
                    ed[b*8 +: 8] = sb[4*(m-1) + off + b];
                    ek[b] = sk[4*(m-1) + off + b];
                end
                chk(m > w + 5 ? "R8 alignment kept" : "R4 aligned data", 64'(al_data), 64'(ed));
                chk("R2 aligned flags", 64'(al_kflag), 64'(ek));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 valid at reset", 64'(al_valid), 64'd0);
        chk("R1 lock at reset", 64'(al_locked), 64'd0);
        chk("R1 data at reset", 64'(al_data), 64'd0);
        chk("R1 flags at reset", 64'(al_kflag), 64'd0);
        rst_n = 1'b1;

        for (int g = 0; g < 2; g++)
            for (int kind = 0; kind < 4; kind++)
                for (int off = 0; off < 4; off++)
                    run_case(off, kind, g[0]);

        // R7: sync code split around a ready drop must not match
        push(32'h0, 4'h0, 1'b1, 1'b0);
        push(32'hAABC0000, 4'b0100, 1'b1, 1'b1);
        push(32'h0, 4'h0, 1'b1, 1'b0);
        push(32'h0000AAAA, 4'b0000, 1'b1, 1'b1);
        chk("R7 split code ignored", 64'(al_locked), 64'd0);
        push(32'h0, 4'h0, 1'b1, 1'b1);
        chk("R7 split code stays unlocked", 64'(al_locked), 64'd0);
        chk("R5 no output after split", 64'(al_valid), 64'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule